// File: doc/BRIEF.md
# Forward State-Metric Recursion Unit for a Four-State Log-MAP Decoder

This block runs the forward (alpha) recursion of a log-domain soft-output decoder for the four-state recursive systematic code with generators (7,5). It advances one trellis step per clock. For each of the four next states it adds the branch metrics of the two incoming transitions to the metrics of the two predecessor states. It keeps the larger of the two sums and adds a small correction term, log(1+exp(-|a-b|)), which a lookup table supplies. The result is the max-star of the two candidates in fixed point.

A parameter picks where the recursion register sits. With `REORDER = 0`, each state's register stores the finished metric. With `REORDER = 1`, the register stores the selected maximum and the correction separately, and the correction is added at the start of the next step, ahead of the branch-metric add. This keeps the table lookup out of the loop's final add. Both placements give the same metric sequence at the ports. Next to each metric the block also reports a decision bit and the correction it used, for replay units further down the chain.

The input is a stream without back-pressure. Whenever `bm_valid` is high, the block accepts the branch metrics on `bm_in` in that cycle. The output is a stream without back-pressure as well. When `sm_valid` is high, the consumer must take the result in that cycle, because the next accepted step overwrites it.

Top module: `fsr_forward_core`

## Requirements
- R1: While reset is asserted, and just after it is released, `sm_valid` is 0, `sm_dec` is 0 and `sm_off` is 0. `sm_out` then holds the seed vector that favours state 0: 189, 0, 63, 0 for states 0 to 3. These are the values 47.25, 0, 15.75, 0 in units of 1/4.
- R2: A state number is {s1,s0}, where s1 is the newer register bit. Next state n has predecessors {n0,0} (candidate A) and {n0,1} (candidate B). A transition from predecessor s0 into next state n carries input u = n1^n0^s0 and parity p = n1^s0. Its branch metric is taken from `bm_in[k*BMW +: BMW]`, an unsigned field, where k = {u,p}.
- R3: Each new metric is the larger candidate (predecessor metric plus branch metric) plus the correction. The decision bit `sm_dec[n]` is 1 only when candidate B is strictly greater than candidate A, so a tie selects A.
- R4: The correction is indexed by min(|A-B|, 7). For index 0 to 7 it is 3, 2, 2, 2, 1, 1, 1, 0, and it is reported in `sm_off[2n +: 2]`.
- R5: A step accepted at a rising edge with `bm_valid` high appears on `sm_out`, `sm_dec` and `sm_off` after that edge, with `sm_valid` high for exactly that one cycle.
- R6: When `bm_start` and `bm_valid` are high together, that step takes the seed vector of R1 as the predecessor metrics instead of the stored metrics.
- R7: When `bm_valid` is low, `sm_valid` goes low and all the other outputs hold their values. `bm_start` on its own has no effect.
- R8: Metrics are W-bit two's-complement values that wrap modulo 2^W. Comparisons use the sign of the wrapped difference, so the results stay correct across wrap-around without any normalisation step.
- R9: `REORDER = 0` and `REORDER = 1` produce identical output sequences for identical input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_valid | input | 1 | Branch metrics on `bm_in` form a step to accept this cycle |
| bm_start | input | 1 | With `bm_valid`, this step starts from the seed vector |
| bm_in | input | 4*BMW | Four unsigned branch metrics, one field per code {u,p} |
| sm_valid | output | 1 | A new result is on the outputs this cycle |
| sm_out | output | 4*W | Forward metric of state n at bits [n*W +: W] |
| sm_dec | output | 4 | Per-state decision: 1 when predecessor B won |
| sm_off | output | 8 | Per-state correction used, 2 bits per state |

## Verification
The recursion is driven with all-zero branch metrics from the seed, which exercises ties and the largest correction. A single favoured code then separates the trellis wiring: a wrong predecessor or code mapping moves the metrics onto the wrong states. Long runs of large pseudo-random metrics with random idle gaps push the metrics through several wrap-arounds, which separates a signed compare from a wrapped one. They also show that outputs hold, and `bm_start` is ignored, while `bm_valid` is low. Restarts in the middle of a stream check the seed path. Both register placements are instantiated side by side on the same stimulus and compared with each other as well as with an integer max-star model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int NSTATE = 4;
  localparam int NCODE  = 4;
  localparam int OFF_W  = 2;
  localparam int MAG_W  = 3;

  // predecessor of next state nxt; sel picks the older register bit
  function automatic int pred_state(int nxt, int sel);
    return ((nxt & 1) << 1) | (sel & 1);
  endfunction

  // branch code {u,p} of the edge pred_state(nxt,sel) -> nxt
  function automatic int branch_code(int nxt, int sel);
    int n1;
    int n0;
    int u;
    int p;
    n1 = (nxt >> 1) & 1;
    n0 = nxt & 1;
    u  = n1 ^ n0 ^ (sel & 1);
    p  = n1 ^ (sel & 1);
    return (u << 1) | p;
  endfunction

  // known-start seed, units of 1/4
  function automatic int seed_metric(int s);
    case (s)
      0:       return 189;
      2:       return 63;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/fsr_offset_lut.sv
module fsr_offset_lut
  import fsr_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  output logic [OFF_W-1:0] off
);
  // ln(1+exp(-d/4)) scaled by 4 and rounded; saturated index gives 0
  always_comb begin
    case (mag)
      3'd0:             off = 2'd3;
      3'd1, 3'd2, 3'd3: off = 2'd2;
      3'd4, 3'd5, 3'd6: off = 2'd1;
      default:          off = 2'd0;
    endcase
  end
endmodule

// File: rtl/fsr_acso.sv
module fsr_acso
  import fsr_pkg::*;
#(
  parameter int W   = 10,
  parameter int BMW = 7
) (
  input  logic [W-1:0]     m_a,
  input  logic [W-1:0]     m_b,
  input  logic [BMW-1:0]   bm_a,
  input  logic [BMW-1:0]   bm_b,
  output logic [W-1:0]     mx,
  output logic [W-1:0]     lose,
  output logic             pick_b,
  output logic [OFF_W-1:0] off
);
  localparam int SAT = (1 << MAG_W) - 1;

  logic [W-1:0]     cand_a;
  logic [W-1:0]     cand_b;
  logic [W-1:0]     diff;
  logic [W-1:0]     mag_full;
  logic [MAG_W-1:0] mag_sat;

  assign cand_a = m_a + W'(bm_a);
  assign cand_b = m_b + W'(bm_b);

  // wrapped difference: its sign is the compare result
  assign diff   = cand_a - cand_b;
  assign pick_b = diff[W-1];

  assign mx   = pick_b ? cand_b : cand_a;
  assign lose = pick_b ? cand_a : cand_b;

  assign mag_full = pick_b ? (cand_b - cand_a) : diff;
  assign mag_sat  = (mag_full >= W'(SAT)) ? MAG_W'(SAT) : mag_full[MAG_W-1:0];

  fsr_offset_lut u_lut (
    .mag (mag_sat),
    .off (off)
  );
endmodule

// File: rtl/fsr_metric_reg.sv
module fsr_metric_reg
  import fsr_pkg::*;
#(
  parameter int W       = 10,
  parameter bit REORDER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     new_max [NSTATE],
  input  logic [OFF_W-1:0] new_off [NSTATE],
  output logic [W-1:0]     metric  [NSTATE]
);
  if (REORDER) begin : g_oacs
    // pre-offset maximum and correction stored apart; added at loop entry
    logic [W-1:0]     max_q [NSTATE];
    logic [OFF_W-1:0] off_q [NSTATE];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < NSTATE; s++) begin
          max_q[s] <= W'(seed_metric(s));
          off_q[s] <= '0;
        end
      end else if (load) begin
        for (int s = 0; s < NSTATE; s++) begin
          max_q[s] <= new_max[s];
          off_q[s] <= new_off[s];
        end
      end
    end

    always_comb begin
      for (int s = 0; s < NSTATE; s++) metric[s] = max_q[s] + W'(off_q[s]);
    end
  end else begin : g_classic
    // finished metric stored; correction add sits at the loop end
    logic [W-1:0] sum_q [NSTATE];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < NSTATE; s++) sum_q[s] <= W'(seed_metric(s));
      end else if (load) begin
        for (int s = 0; s < NSTATE; s++) sum_q[s] <= new_max[s] + W'(new_off[s]);
      end
    end

    always_comb begin
      for (int s = 0; s < NSTATE; s++) metric[s] = sum_q[s];
    end
  end
endmodule

// File: rtl/fsr_forward_core.sv
module fsr_forward_core
  import fsr_pkg::*;
#(
  parameter int W       = 10,
  parameter int BMW     = 7,
  parameter bit REORDER = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bm_valid,
  input  logic                    bm_start,
  input  logic [NCODE*BMW-1:0]    bm_in,
  output logic                    sm_valid,
  output logic [NSTATE*W-1:0]     sm_out,
  output logic [NSTATE-1:0]       sm_dec,
  output logic [NSTATE*OFF_W-1:0] sm_off
);
  logic [W-1:0]      cur     [NSTATE];
  logic [W-1:0]      prior   [NSTATE];
  logic [W-1:0]      nx_max  [NSTATE];
  logic [W-1:0]      nx_lose [NSTATE];
  logic [W-1:0]      gap     [NSTATE];
  logic [OFF_W-1:0]  nx_off  [NSTATE];
  logic [NSTATE-1:0] nx_dec;

  for (genvar s = 0; s < NSTATE; s++) begin : g_prior
    assign prior[s] = bm_start ? W'(seed_metric(s)) : cur[s];
  end

  for (genvar n = 0; n < NSTATE; n++) begin : g_state
    localparam int PA = pred_state(n, 0);
    localparam int PB = pred_state(n, 1);
    localparam int CA = branch_code(n, 0);
    localparam int CB = branch_code(n, 1);

    fsr_acso #(.W(W), .BMW(BMW)) u_acso (
      .m_a    (prior[PA]),
      .m_b    (prior[PB]),
      .bm_a   (bm_in[CA*BMW +: BMW]),
      .bm_b   (bm_in[CB*BMW +: BMW]),
      .mx     (nx_max[n]),
      .lose   (nx_lose[n]),
      .pick_b (nx_dec[n]),
      .off    (nx_off[n])
    );

    assign sm_out[n*W +: W] = cur[n];
    assign gap[n] = nx_max[n] - nx_lose[n];

    AST_WINNER_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      bm_valid |-> !gap[n][W-1]) else $error("winner below loser"); // R3
    AST_FAR_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_valid && gap[n] >= W'(7)) |-> nx_off[n] == '0) else $error("offset on far pair"); // R4
  end

  fsr_metric_reg #(.W(W), .REORDER(REORDER)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bm_valid),
    .new_max (nx_max),
    .new_off (nx_off),
    .metric  (cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sm_valid <= 1'b0;
      sm_dec   <= '0;
      sm_off   <= '0;
    end else begin
      sm_valid <= bm_valid;
      if (bm_valid) begin
        sm_dec <= nx_dec;
        for (int n = 0; n < NSTATE; n++) sm_off[n*OFF_W +: OFF_W] <= nx_off[n];
      end
    end
  end

  AST_STEP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bm_valid |=> sm_valid) else $error("step result missing"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_valid |=> (!sm_valid && $stable(sm_out) && $stable(sm_dec) && $stable(sm_off)))
    else $error("outputs moved while idle"); // R7
endmodule

// File: tb/sim_fsr_forward_core.sv
`timescale 1ns/1ps
module sim_fsr_forward_core;
  localparam int W   = 10;
  localparam int BMW = 7;
  localparam int NS  = 4;

  typedef struct packed {
    logic [NS*W-1:0] sm;
    logic [NS-1:0]   dec;
    logic [NS*2-1:0] off;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bm_valid = 1'b0;
  logic bm_start = 1'b0;
  logic [NS*BMW-1:0] bm_in = '0;

  logic            v0, v1;
  logic [NS*W-1:0] sm0, sm1;
  logic [NS-1:0]   d0, d1;
  logic [NS*2-1:0] o0, o1;

  fsr_forward_core #(.W(W), .BMW(BMW), .REORDER(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm_start(bm_start), .bm_in(bm_in),
    .sm_valid(v0), .sm_out(sm0), .sm_dec(d0), .sm_off(o0));
  fsr_forward_core #(.W(W), .BMW(BMW), .REORDER(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm_start(bm_start), .bm_in(bm_in),
    .sm_valid(v1), .sm_out(sm1), .sm_dec(d1), .sm_off(o1));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint seed_v [NS] = '{189, 0, 63, 0};
  longint mdl [NS];
  exp_t q [$];
  logic [NS*W-1:0] last_sm;
  logic [NS*W-1:0] seed_pack;
  int unsigned rng = 32'h1234_5678;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int corr(longint m);
    if (m >= 7) return 0;
    case (m)
      0:       return 3;
      1, 2, 3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned nxt_rng();
    rng = rng * 32'd1103515245 + 32'd12345;
    return rng >> 8;
  endfunction

  // driver: one accepted step; the model result goes to the scoreboard
  task automatic step(logic [NS*BMW-1:0] bm, bit start);
    longint prior [NS];
    longint nv [NS];
    exp_t e;
    @(negedge clk);
    bm_valid = 1'b1;
    bm_start = start;
    bm_in    = bm;
    for (int s = 0; s < NS; s++) prior[s] = start ? seed_v[s] : mdl[s];
    for (int n = 0; n < NS; n++) begin
      int n1, n0, ka, kb;
      longint ca, cb, mx, mag;
      bit db;
      n1 = (n >> 1) & 1;
      n0 = n & 1;
      ka = ((n1 ^ n0) << 1) | n1;
      kb = ((n1 ^ n0 ^ 1) << 1) | (n1 ^ 1);
      ca = prior[2*n0]     + longint'(bm[ka*BMW +: BMW]);
      cb = prior[2*n0 + 1] + longint'(bm[kb*BMW +: BMW]);
      db  = cb > ca;
      mx  = db ? cb : ca;
      mag = db ? cb - ca : ca - cb;
      nv[n] = mx + corr(mag);
      e.sm[n*W +: W] = nv[n][W-1:0];
      e.dec[n]       = db;
      e.off[n*2 +: 2] = 2'(corr(mag));
    end
    for (int s = 0; s < NS; s++) mdl[s] = nv[s];
    q.push_back(e);
  endtask

  task automatic idle(bit start);
    @(negedge clk);
    bm_valid = 1'b0;
    bm_start = start;
    bm_in    = NS*BMW'(nxt_rng());
  endtask

  function automatic logic [NS*BMW-1:0] rand_bm();
    logic [NS*BMW-1:0] b;
    for (int k = 0; k < NS; k++) b[k*BMW +: BMW] = BMW'(nxt_rng());
    return b;
  endfunction

  // monitor: pops one expected item for every valid result
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(v0 == 1'b1 && v1 == 1'b1, "R5 valid after step", longint'(v0), 1);
        check(sm0 == e.sm, "R2 R3 R6 R8 metric u0", longint'(sm0), longint'(e.sm));
        check(sm1 == e.sm, "R2 R3 R6 R8 metric u1", longint'(sm1), longint'(e.sm));
        check(d0 == e.dec && d1 == e.dec, "R3 decision", longint'(d0), longint'(e.dec));
        check(o0 == e.off && o1 == e.off, "R4 offset", longint'(o0), longint'(e.off));
        check(sm0 == sm1 && d0 == d1 && o0 == o1, "R9 modes agree", longint'(sm0), longint'(sm1));
      end else begin
        check(v0 == 1'b0 && v1 == 1'b0, "R5 R7 valid low when idle", longint'(v0), 0);
        check(sm0 == last_sm && sm1 == last_sm, "R7 hold when idle", longint'(sm0), longint'(last_sm));
      end
      last_sm = sm0;
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mdl[s] = seed_v[s];
      seed_pack[s*W +: W] = seed_v[s][W-1:0];
    end
    last_sm = seed_pack;
    repeat (3) @(posedge clk);
    #1;
    check(v0 == 1'b0 && v1 == 1'b0, "R1 valid in reset", longint'(v0), 0);
    check(sm0 == seed_pack && sm1 == seed_pack, "R1 seed in reset", longint'(sm0), longint'(seed_pack));
    check(d0 == '0 && o0 == '0 && d1 == '0 && o1 == '0, "R1 dec/off in reset", longint'(o0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1'b0);
    // ties and largest correction from the seed
    step('0, 1'b1);
    repeat (5) step('0, 1'b0);
    // one favoured code: exposes trellis wiring
    for (int k = 0; k < NS; k++) begin
      logic [NS*BMW-1:0] b;
      b = '0;
      b[k*BMW +: BMW] = BMW'(20);
      step('0, 1'b1);
      repeat (6) step(b, 1'b0);
    end
    // start alone must do nothing
    idle(1'b1);
    idle(1'b1);
    idle(1'b0);
    // long random run through many wraps, with gaps and restarts
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = nxt_rng();
      if (r % 5 == 0) idle(r[9]);
      else step(rand_bm(), (r % 61) == 7);
    end
    // small equal metrics near ties
    step({NS{BMW'(5)}}, 1'b1);
    repeat (4) step({NS{BMW'(5)}}, 1'b0);
    idle(1'b0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule